// File: doc/BRIEF.md
# Paired External Interrupt Controller

This block collects eight interrupt request lines, arranged as four pairs named A to D. Each pair has an even channel and an odd channel. Every line passes through a synchroniser and an edge detector. The edge polarity is set per channel, and a detected edge latches a pending flag. Each channel has its own enable bit. Of all pending, enabled channels, the block presents the one with the best priority to the core, together with its channel index and its level. The core answers with a one-cycle acknowledge, which retires the presented request.

Priority is configured per pair, not per channel. Each pair has a 2-bit field. The even channel runs at level `{field,0}` and the odd channel at level `{field,1}`, so the odd member always ranks just below its partner. The even channel of every pair can be driven either from its external pin or from an on-chip peripheral request. A source-select register picks which one.

Software reaches the block through a write-only register bus with five registers:
- trigger, address 0
- pending, address 1
- enable, address 2
- priority, address 3
- source select, address 4

Top module: `pair_irq_top`

## Requirements
- R1: A level change on a selected input line sets the pending flag at the third rising clock edge after the change. The first two edges are the synchroniser and the third is the edge detector. An enabled channel is visible on the outputs after that third edge.
- R2: The channel index encoding is A0=0, A1=1, B0=2, B1=3, C0=4, C1=5, D0=6, D1=7. Trigger register bit i belongs to channel index i. A bit value of 1 latches pending on a rising edge, and 0 latches it on a falling edge. An edge of the other polarity has no effect.
- R3: In the enable register, channel index i uses bit 7-i, so A0 is bit 7 and D1 is bit 0. A bit value of 1 enables the channel. A disabled channel still latches pending and is presented once it is enabled. An edge that lands in the same cycle as an enable write still latches pending.
- R4: `irqValid` is high exactly when some channel is both pending and enabled. While it is high, `irqChan` and `irqLevel` identify the winner. While it is low, both outputs are 0.
- R5: The priority register holds pair fields D in bits 7:6, C in bits 5:4, B in bits 3:2 and A in bits 1:0. The even channel's level is {field,0} and the odd channel's level is {field,1}. With the value 8'b1000_1001 the levels are A0=2, A1=3, B0=4, B1=5, C0=0, C1=1, D0=4 and D1=5.
- R6: A numerically lower level wins. Among equal levels, the lower channel index wins.
- R7: An `ackPulse` while `irqValid` is high clears the pending flag of the presented channel. An `ackPulse` while `irqValid` is low changes nothing.
- R8: Writing the pending register clears every bit written as 0 and keeps every bit written as 1. A new edge in the same cycle as a clear leaves that flag set.
- R9: The source-select register has five bits:
  - Bit 0 drives A0: 1 selects `extPin[0]`, 0 selects `periphReq[0]`.
  - Bit 1 drives C0: 1 selects `extPin[4]`, 0 selects `periphReq[2]`.
  - Bit 2 drives D0: 0 selects `extPin[6]`, 1 selects `periphReq[3]`.
  - Bits 4:3 drive B0: 00 selects `extPin[2]`, any other value selects `periphReq[1]`.
  - The reset value is 5'b00011, which routes every even channel to its pin.
- R10: After reset, no flag is pending, every channel is disabled, every trigger selects a falling edge and the priority register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 8 | External request pins, bit i feeds channel index i |
| periphReq | input | 4 | Peripheral requests for the even channels of pairs A, B, C, D |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| ackPulse | input | 1 | Core acknowledge of the presented request |
| irqValid | output | 1 | A pending, enabled request is presented |
| irqChan | output | 3 | Index of the presented channel |
| irqLevel | output | 3 | Level of the presented channel |

## Verification
The bench drives all eight lines high at once under the mixed priority value and then acknowledges its way through the whole order. This catches a design that inverts the even/odd level bit or swaps pair fields, because the retire order would come out wrong. The B0/D0 tie at level 4 exposes an arbiter that favours the higher index. An acknowledge given while the only pending channel is disabled must not clear it. A design that forgets to gate the acknowledge would drop the A0 request, because the idle index output is 0. An edge that coincides with a pending-clear write or an enable write must still latch, so an implementation that applies the clear last or samples the enable would lose a request.

// File: rtl/pair_irq_pkg.sv
package pair_irq_pkg;
  localparam int PAIRS   = 4;
  localparam int CH      = 2 * PAIRS;
  localparam int CHW     = $clog2(CH);
  localparam int PFW     = 2;
  localparam int LVW     = PFW + 1;
  localparam int PRIO_W  = PAIRS * PFW;
  localparam int ADDR_W  = 3;
  localparam int SRC_W   = 5;

  localparam logic [ADDR_W-1:0] ADDR_TRIG = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PRIO = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SRC  = 3'd4;

  localparam logic [SRC_W-1:0] SRC_RST = 5'b00011;
  localparam int SRC_A0  = 0;
  localparam int SRC_C0  = 1;
  localparam int SRC_D0  = 2;
  localparam int SRC_B0L = 3;

  typedef struct packed {
    logic          wrTrig;
    logic          wrPend;
    logic          wrEn;
    logic          wrPrio;
    logic          wrSrc;
    logic          ackGo;
    logic [CH-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/pair_irq_ctrl.sv
module pair_irq_ctrl
  import pair_irq_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CH-1:0]     regWdata,
  input  logic              ackPulse,
  input  logic              irqValid,
  output strobe_t           strb
);
  always_comb begin
    strb       = '0;
    strb.wdata = regWdata;
    if (regWe) begin
      case (regAddr)
        ADDR_TRIG: strb.wrTrig = 1'b1;
        ADDR_PEND: strb.wrPend = 1'b1;
        ADDR_EN:   strb.wrEn   = 1'b1;
        ADDR_PRIO: strb.wrPrio = 1'b1;
        ADDR_SRC:  strb.wrSrc  = 1'b1;
        default:   strb.wrTrig = 1'b0;
      endcase
    end
    // an acknowledge only counts while a request is presented
    strb.ackGo = ackPulse & irqValid;
  end
endmodule

// File: rtl/pair_irq_dp.sv
module pair_irq_dp
  import pair_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CH-1:0]    extPin,
  input  logic [PAIRS-1:0] periphReq,
  input  strobe_t          strb,
  output logic             irqValid,
  output logic [CHW-1:0]   irqChan,
  output logic [LVW-1:0]   irqLevel,
  output logic [CH-1:0]    pendVec,
  output logic [CH-1:0]    enVec
);
  logic [CH-1:0]     trigReg, pendReg, maskReg;
  logic [PRIO_W-1:0] prioReg;
  logic [SRC_W-1:0]  srcReg;
  logic [CH-1:0]     rawLine, syncA, syncB, prevLine, edgeHit;
  logic [CH-1:0]     ackClr, wrClr, pendNext, cand;
  logic [LVW-1:0]    chLevel [CH];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigReg <= '0;
      maskReg <= '0;
      prioReg <= '0;
      srcReg  <= SRC_RST;
    end else begin
      if (strb.wrTrig) trigReg <= strb.wdata;
      if (strb.wrEn)   maskReg <= strb.wdata;
      if (strb.wrPrio) prioReg <= strb.wdata[PRIO_W-1:0];
      if (strb.wrSrc)  srcReg  <= strb.wdata[SRC_W-1:0];
    end
  end

  // even-channel source selection
  always_comb begin
    rawLine    = extPin;
    rawLine[0] = srcReg[SRC_A0] ? extPin[0] : periphReq[0];
    rawLine[2] = (srcReg[SRC_B0L+1:SRC_B0L] == 2'b00) ? extPin[2] : periphReq[1];
    rawLine[4] = srcReg[SRC_C0] ? extPin[4] : periphReq[2];
    rawLine[6] = srcReg[SRC_D0] ? periphReq[3] : extPin[6];
  end

  // two-flop synchroniser plus one history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      prevLine <= '0;
    end else begin
      syncA    <= rawLine;
      syncB    <= syncA;
      prevLine <= syncB;
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_chan
    assign edgeHit[g] = trigReg[g] ? (syncB[g] & ~prevLine[g])
                                   : (~syncB[g] & prevLine[g]);
    assign enVec[g]   = maskReg[CH-1-g];
    assign chLevel[g] = {prioReg[(g/2)*PFW +: PFW], 1'(g % 2)};
  end

  // pending update: clears first, fresh edges win
  always_comb begin
    ackClr   = strb.ackGo  ? (CH'(1) << irqChan) : '0;
    wrClr    = strb.wrPend ? ~strb.wdata : '0;
    pendNext = (pendReg & ~(ackClr | wrClr)) | edgeHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendReg <= '0;
    else       pendReg <= pendNext;
  end

  // arbiter: lowest level, lowest index on ties
  always_comb begin
    cand     = pendReg & enVec;
    irqValid = 1'b0;
    irqChan  = '0;
    irqLevel = '0;
    for (int i = 0; i < CH; i++) begin
      if (cand[i] && (!irqValid || chLevel[i] < irqLevel)) begin
        irqValid = 1'b1;
        irqChan  = CHW'(i);
        irqLevel = chLevel[i];
      end
    end
  end

  assign pendVec = pendReg;
endmodule

// File: rtl/pair_irq_top.sv
module pair_irq_top
  import pair_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CH-1:0]    extPin,
  input  logic [PAIRS-1:0] periphReq,
  input  logic             regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CH-1:0]    regWdata,
  input  logic             ackPulse,
  output logic             irqValid,
  output logic [CHW-1:0]   irqChan,
  output logic [LVW-1:0]   irqLevel
);
  strobe_t       strb;
  logic [CH-1:0] pendVec, enVec;

  pair_irq_ctrl u_ctrl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .ackPulse (ackPulse),
    .irqValid (irqValid),
    .strb     (strb)
  );

  pair_irq_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extPin    (extPin),
    .periphReq (periphReq),
    .strb      (strb),
    .irqValid  (irqValid),
    .irqChan   (irqChan),
    .irqLevel  (irqLevel),
    .pendVec   (pendVec),
    .enVec     (enVec)
  );
endmodule

// File: rtl/pair_irq_chk.sv
module pair_irq_chk
  import pair_irq_pkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           irqValid,
  input logic [CHW-1:0] irqChan,
  input logic [LVW-1:0] irqLevel,
  input logic [CH-1:0]  pendVec,
  input logic [CH-1:0]  enVec
);
  // R4
  valid_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (pendVec[irqChan] && enVec[irqChan]));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqValid |-> (irqChan == '0 && irqLevel == '0));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & enVec) == '0) |-> !irqValid);

  // R5
  odd_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqLevel[0] == irqChan[0]));

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendVec == '0 && enVec == '0));
endmodule

bind pair_irq_top pair_irq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqValid (irqValid),
  .irqChan  (irqChan),
  .irqLevel (irqLevel),
  .pendVec  (pendVec),
  .enVec    (enVec)
);

// File: tb/pair_irq_top_bench.sv
module pair_irq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] extPin;
  logic [3:0] periphReq;
  logic       regWe;
  logic [2:0] regAddr;
  logic [7:0] regWdata;
  logic       ackPulse;
  logic       irqValid;
  logic [2:0] irqChan;
  logic [2:0] irqLevel;

  int nChecks = 0;
  int nErr    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pair_irq_top u_pair_irq_top (
    .clk(clk), .rstN(rstN), .extPin(extPin), .periphReq(periphReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .ackPulse(ackPulse),
    .irqValid(irqValid), .irqChan(irqChan), .irqLevel(irqLevel)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic ack();
    ackPulse = 1'b1;
    tick(1);
    ackPulse = 1'b0;
  endtask

  task automatic chk(string tag, logic v, logic [2:0] ch, logic [2:0] lv);
    logic [6:0] act, exp;
    act = {irqValid, irqChan, irqLevel};
    exp = {v, ch, lv};
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: got v=%b ch=%0d lv=%0d expected v=%b ch=%0d lv=%0d",
               tag, act[6], act[5:3], act[2:0], v, ch, lv);
    end
  endtask

  task automatic t_reset();
    chk("R10 idle after reset", 0, 0, 0);
    extPin[0] = 1'b1; tick(4);
    chk("R10 rising ignored on falling default", 0, 0, 0);
    extPin[0] = 1'b0; tick(4);
    chk("R10 all disabled after reset", 0, 0, 0);
    wrReg(3'd2, 8'hFF);
    chk("R10 priority zero gives A0 level 0", 1, 0, 0);
    ack();
    chk("R7 ack clears A0", 0, 0, 0);
    extPin[1] = 1'b1; tick(4);
    extPin[1] = 1'b0; tick(2);
    chk("R1 not yet pending after two edges", 0, 0, 0);
    tick(1);
    chk("R1 pending at third edge", 1, 1, 1);
    ack();
  endtask

  task automatic t_trigger();
    wrReg(3'd0, 8'hFF);
    extPin[3] = 1'b1; tick(4);
    chk("R2 rising edge on B1", 1, 3, 1);
    ack();
    extPin[3] = 1'b0; tick(4);
    chk("R2 falling ignored when rising chosen", 0, 0, 0);
  endtask

  task automatic t_prio();
    wrReg(3'd3, 8'b1000_1001);
    extPin = 8'hFF; tick(4);
    chk("R5 C0 level 0 first", 1, 4, 0);
    ack(); chk("R5 C1 level 1", 1, 5, 1);
    ack(); chk("R5 A0 level 2", 1, 0, 2);
    ack(); chk("R5 A1 level 3", 1, 1, 3);
    ack(); chk("R6 tie B0 over D0", 1, 2, 4);
    ack(); chk("R6 D0 after B0", 1, 6, 4);
    ack(); chk("R6 tie B1 over D1", 1, 3, 5);
    ack(); chk("R5 D1 level 5", 1, 7, 5);
    ack(); chk("R7 all retired", 0, 0, 0);
    extPin = 8'h00; tick(4);
  endtask

  task automatic t_mask();
    wrReg(3'd2, 8'h7F);
    extPin[0] = 1'b1; tick(4);
    chk("R3 A0 disabled via bit 7", 0, 0, 0);
    ack();
    wrReg(3'd2, 8'hFF);
    chk("R7 ack while idle kept A0 pending", 1, 0, 2);
    ack();
    wrReg(3'd2, 8'hFE);
    extPin[7] = 1'b1; tick(4);
    chk("R3 D1 disabled via bit 0", 0, 0, 0);
    wrReg(3'd2, 8'hFF);
    chk("R3 D1 shown once enabled", 1, 7, 5);
    ack();
    extPin[0] = 1'b0; extPin[7] = 1'b0; tick(4);
    wrReg(3'd2, 8'h00);
    extPin[1] = 1'b1; tick(2);
    wrReg(3'd2, 8'hFF);
    chk("R3 edge during enable write latched", 1, 1, 3);
    ack();
    extPin[1] = 1'b0; tick(4);
  endtask

  task automatic t_pendwr();
    extPin[2] = 1'b1; extPin[3] = 1'b1; tick(4);
    chk("R8 B0 first", 1, 2, 4);
    wrReg(3'd1, 8'hFF);
    chk("R8 ones keep pending", 1, 2, 4);
    wrReg(3'd1, 8'hFB);
    chk("R8 zero clears B0", 1, 3, 5);
    extPin[3] = 1'b0; tick(4);
    extPin[3] = 1'b1; tick(2);
    wrReg(3'd1, 8'hF7);
    chk("R8 edge wins over clear", 1, 3, 5);
    wrReg(3'd1, 8'hF7);
    chk("R8 clear B1", 0, 0, 0);
    extPin[2] = 1'b0; extPin[3] = 1'b0; tick(4);
  endtask

  task automatic t_src();
    wrReg(3'd4, 5'b00010);
    extPin[0] = 1'b1; tick(4);
    chk("R9 A0 pin ignored when peripheral chosen", 0, 0, 0);
    periphReq[0] = 1'b1; tick(4);
    chk("R9 A0 from peripheral", 1, 0, 2);
    ack();
    wrReg(3'd4, 5'b01011);
    periphReq[1] = 1'b1; tick(4);
    chk("R9 B0 from peripheral", 1, 2, 4);
    ack();
    wrReg(3'd4, 5'b01111);
    periphReq[3] = 1'b1; tick(4);
    chk("R9 D0 from peripheral", 1, 6, 4);
    ack();
    wrReg(3'd4, 5'b01101);
    periphReq[2] = 1'b1; tick(4);
    chk("R9 C0 from peripheral", 1, 4, 0);
    ack();
    chk("R9 nothing left", 0, 0, 0);
  endtask

  initial begin
    rstN = 1'b0; extPin = '0; periphReq = '0;
    regWe = 1'b0; regAddr = '0; regWdata = '0; ackPulse = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_trigger();
    t_prio();
    t_mask();
    t_pendwr();
    t_src();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nErr++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule